// File: doc/BRIEF.md
# Discovery Request Responder

This block answers protocol enumeration queries that software places in a request buffer as a small data object. When `start` is pulsed, the block reads the request's length dword and its index dword through a read port with one cycle of latency. It then looks up the protocol table at the requested index and writes a three-dword response object through a write port. Software walks the whole table by issuing one query per entry. Each answer carries the index to ask for next, and that index returns to zero after the last entry.

The protocol table always holds two fixed entries at positions 0 and 1: discovery itself and a second standard type. The remaining positions and the entry count can be loaded through a write port while no request is in flight. A request whose declared length is too short for a discovery query is dropped. In that case a one-cycle `discard` pulse replaces the response.

Top module: `disc_responder`

## Requirements
- R1: After a synchronous reset, `done`, `discard`, `rsp_we` and `req_rd_en` are low, `rsp_len` is 0, and the table count is 2.
- R2: An accepted `start` makes the block read request dword 1 (`req_rd_addr`=1) in the next cycle and dword 2 in the cycle after that. Read data is expected on `req_rd_data` one cycle after each read.
- R3: If the length field of request dword 1 (bits 17:0, in dwords) is below 3, the block writes no response. It pulses `discard` for one cycle and sets `rsp_len` to 0. Bits 31:18 of dword 1 play no part in this test.
- R4: An accepted request writes response dword 0 = 0x00000001 (vendor 0x0001 in bits 15:0, type 0x00 in bits 23:16) at address 0, then dword 1 = 0x00000003 (length 3) at address 1, on consecutive cycles.
- R5: Response dword 2 is written at address 2 in the next cycle. For an index below the count it holds the entry's vendor in bits 15:0, the entry's type in bits 23:16 and the next index in bits 31:24. The index is byte 0 of request dword 2.
- R6: An index equal to or above the count yields vendor 0xFFFF, type 0xFF and next index 0.
- R7: The next index is the requested index plus one when that is below the count, and 0 otherwise.
- R8: Entry 0 reads as vendor 0x0001 type 0x00 and entry 1 as vendor 0x0001 type 0x01. Table writes to positions 0 and 1 have no effect.
- R9: A count write stores the value, clamped to the range 2 to ENTRIES (256 by default).
- R10: While a request is in progress, table writes, count writes and further `start` pulses are ignored.
- R11: `done` pulses for one cycle, in the cycle after the dword 2 write. `rsp_len` becomes 3 at the same time and holds until the next completion or discard. `done` and `discard` are never high together.
- R12: A length field of 3 or more is accepted and answered normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin servicing the request in the buffer |
| req_rd_en | output | 1 | Request buffer read enable |
| req_rd_addr | output | 2 | Request dword address |
| req_rd_data | input | 32 | Request dword, valid one cycle after the read |
| rsp_we | output | 1 | Response buffer write enable |
| rsp_addr | output | 2 | Response dword address |
| rsp_data | output | 32 | Response dword |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | AW | Table position to write |
| tbl_vendor | input | 16 | Vendor ID to store |
| tbl_type | input | 8 | Object type to store |
| cnt_we | input | 1 | Count write strobe |
| cnt_val | input | AW+1 | New entry count |
| done | output | 1 | One-cycle completion pulse |
| discard | output | 1 | One-cycle pulse for a dropped request |
| rsp_len | output | 18 | Length of the last response in dwords |

## Verification
The assertions check the fixed properties of every write cycle on each clock. These are the constant header dwords, `done` following the dword 2 write, the response length reported with `done` and `discard`, and the mutual exclusion of the two pulses. What only the scenarios show is the data path: payload values for valid, out-of-range and wrapping indices, the fixed entries resisting overwrite, count clamping at both ends, and writes and `start` ignored during a request. The bench checks these against a behavioural model that tracks the table and request timing on every clock.

// File: rtl/disc_pkg.sv
package disc_pkg;
  localparam int DW        = 32;
  localparam int LENW      = 18;
  localparam int RIDXW     = 8;
  localparam int MIN_LEN   = 3;
  localparam logic [15:0] VENDOR_STD  = 16'h0001;
  localparam logic [7:0]  TYPE_DISC   = 8'h00;
  localparam logic [7:0]  TYPE_SECOND = 8'h01;
  localparam logic [15:0] VENDOR_NONE = 16'hFFFF;
  localparam logic [7:0]  TYPE_NONE   = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD2, ST_LEN, ST_IDX, ST_HDR1, ST_PAY, ST_FIN
  } st_t;

  typedef struct packed {
    logic [15:0] vendor;
    logic [7:0]  ptype;
  } proto_t;
endpackage

// File: rtl/disc_proto_table.sv
module disc_proto_table
  import disc_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int AW = $clog2(ENTRIES),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  proto_t        wr_ent,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_val,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_idx,
  output proto_t        rd_ent,
  output logic [CW-1:0] count
);
  proto_t     mem [ENTRIES];
  proto_t     mem_q;
  logic [1:0] fix_q;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en && !lock && wr_idx >= AW'(2)) mem[wr_idx] <= wr_ent;
    if (rd_en) mem_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_q <= '0;
      count <= CW'(2);
    end else begin
      if (rd_en) fix_q <= {rd_idx == AW'(1), rd_idx == AW'(0)};
      if (cnt_we && !lock) begin
        if (cnt_val < CW'(2))            count <= CW'(2);
        else if (cnt_val > CW'(ENTRIES)) count <= CW'(ENTRIES);
        else                             count <= cnt_val;
      end
    end
  end

  always_comb begin
    if (fix_q[0])      rd_ent = '{vendor: VENDOR_STD, ptype: TYPE_DISC};
    else if (fix_q[1]) rd_ent = '{vendor: VENDOR_STD, ptype: TYPE_SECOND};
    else               rd_ent = mem_q;
  end
endmodule

// File: rtl/disc_payload.sv
module disc_payload
  import disc_pkg::*;
#(
  parameter int CW = 9,
  localparam int XW = ((CW > RIDXW) ? CW : RIDXW) + 1
) (
  input  logic [RIDXW-1:0] idx,
  input  logic [CW-1:0]    count,
  input  proto_t           ent,
  output logic [DW-1:0]    word
);
  logic [XW-1:0] idx_x, cnt_x, nxt_x;
  logic in_range, more;

  always_comb begin
    idx_x    = XW'(idx);
    cnt_x    = XW'(count);
    nxt_x    = idx_x + XW'(1);
    in_range = idx_x < cnt_x;
    more     = nxt_x < cnt_x;
    word = {more ? nxt_x[7:0] : 8'h00,
            in_range ? ent.ptype  : TYPE_NONE,
            in_range ? ent.vendor : VENDOR_NONE};
  end
endmodule

// File: rtl/disc_responder.sv
module disc_responder
  import disc_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int AW = $clog2(ENTRIES),
  localparam int CW = AW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic            req_rd_en,
  output logic [1:0]      req_rd_addr,
  input  logic [DW-1:0]   req_rd_data,
  output logic            rsp_we,
  output logic [1:0]      rsp_addr,
  output logic [DW-1:0]   rsp_data,
  input  logic            tbl_we,
  input  logic [AW-1:0]   tbl_idx,
  input  logic [15:0]     tbl_vendor,
  input  logic [7:0]      tbl_type,
  input  logic            cnt_we,
  input  logic [CW-1:0]   cnt_val,
  output logic            done,
  output logic            discard,
  output logic [LENW-1:0] rsp_len
);
  st_t              state;
  logic [LENW-1:0]  len_q;
  logic [RIDXW-1:0] idx_q;
  proto_t           ent;
  logic [CW-1:0]    count;
  logic [DW-1:0]    pay_w;
  logic             unused_hi;

  assign unused_hi = ^req_rd_data[DW-1:LENW];

  disc_proto_table #(.ENTRIES(ENTRIES)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .lock    (state != ST_IDLE),
    .wr_en   (tbl_we),
    .wr_idx  (tbl_idx),
    .wr_ent  ({tbl_vendor, tbl_type}),
    .cnt_we  (cnt_we),
    .cnt_val (cnt_val),
    .rd_en   (state == ST_IDX),
    .rd_idx  (req_rd_data[AW-1:0]),
    .rd_ent  (ent),
    .count   (count)
  );

  disc_payload #(.CW(CW)) u_pay (
    .idx   (idx_q),
    .count (count),
    .ent   (ent),
    .word  (pay_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      req_rd_en   <= 1'b0;
      req_rd_addr <= '0;
      rsp_we      <= 1'b0;
      rsp_addr    <= '0;
      rsp_data    <= '0;
      done        <= 1'b0;
      discard     <= 1'b0;
      rsp_len     <= '0;
      len_q       <= '0;
      idx_q       <= '0;
    end else begin
      req_rd_en <= 1'b0;
      rsp_we    <= 1'b0;
      done      <= 1'b0;
      discard   <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          req_rd_en   <= 1'b1;
          req_rd_addr <= 2'd1;
          state       <= ST_RD2;
        end
        ST_RD2: begin
          req_rd_en   <= 1'b1;
          req_rd_addr <= 2'd2;
          state       <= ST_LEN;
        end
        ST_LEN: begin
          len_q <= req_rd_data[LENW-1:0];
          state <= ST_IDX;
        end
        ST_IDX: begin
          idx_q <= req_rd_data[RIDXW-1:0];
          if (len_q < LENW'(MIN_LEN)) begin
            discard <= 1'b1;
            rsp_len <= '0;
            state   <= ST_IDLE;
          end else begin
            rsp_we   <= 1'b1;
            rsp_addr <= 2'd0;
            rsp_data <= {8'h00, TYPE_DISC, VENDOR_STD};
            state    <= ST_HDR1;
          end
        end
        ST_HDR1: begin
          rsp_we   <= 1'b1;
          rsp_addr <= 2'd1;
          rsp_data <= DW'(MIN_LEN);
          state    <= ST_PAY;
        end
        ST_PAY: begin
          rsp_we   <= 1'b1;
          rsp_addr <= 2'd2;
          rsp_data <= pay_w;
          state    <= ST_FIN;
        end
        ST_FIN: begin
          done    <= 1'b1;
          rsp_len <= LENW'(MIN_LEN);
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/disc_checks.sv
module disc_checks
  import disc_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            req_rd_en,
  input logic            rsp_we,
  input logic [1:0]      rsp_addr,
  input logic [DW-1:0]   rsp_data,
  input logic            done,
  input logic            discard,
  input logic [LENW-1:0] rsp_len
);
  assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(done && discard));

  assert_hdr0_word_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_we && rsp_addr == 2'd0) |-> rsp_data == 32'h0000_0001);

  assert_hdr1_len_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_we && rsp_addr == 2'd1) |-> rsp_data == 32'h0000_0003);

  assert_done_follows_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_we && rsp_addr == 2'd2) |=> done);

  assert_done_len_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> rsp_len == LENW'(3));

  assert_discard_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    discard |-> (rsp_len == '0 && !rsp_we));

  assert_read_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    req_rd_en |-> !rsp_we);
endmodule

bind disc_responder disc_checks u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_rd_en (req_rd_en),
  .rsp_we    (rsp_we),
  .rsp_addr  (rsp_addr),
  .rsp_data  (rsp_data),
  .done      (done),
  .discard   (discard),
  .rsp_len   (rsp_len)
);

// File: tb/sim_disc_responder.sv
module sim_disc_responder;
  localparam int AW = 8;
  localparam int CW = 9;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic start = 0, tbl_we = 0, cnt_we = 0;
  logic [AW-1:0] tbl_idx = '0;
  logic [15:0] tbl_vendor = '0;
  logic [7:0] tbl_type = '0;
  logic [CW-1:0] cnt_val = '0;
  logic req_rd_en, rsp_we, done, discard;
  logic [1:0] req_rd_addr, rsp_addr;
  logic [31:0] req_rd_data = '0, rsp_data;
  logic [17:0] rsp_len;

  logic [31:0] reqmem [4];
  always @(posedge clk) if (req_rd_en) req_rd_data <= reqmem[req_rd_addr];

  disc_responder u0 (.clk(clk), .rst(rst), .start(start), .req_rd_en(req_rd_en),
    .req_rd_addr(req_rd_addr), .req_rd_data(req_rd_data), .rsp_we(rsp_we),
    .rsp_addr(rsp_addr), .rsp_data(rsp_data), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_vendor(tbl_vendor), .tbl_type(tbl_type), .cnt_we(cnt_we), .cnt_val(cnt_val),
    .done(done), .discard(discard), .rsp_len(rsp_len));

  int compared = 0, mismatched = 0, cyc = 0;
  logic [31:0] last_pay = '0;

  task automatic cmp(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_busy, m_ph, m_len, m_idx, m_cnt;
  int m_vend [256];
  int m_typ  [256];
  logic e_rd_en, e_we, e_done, e_disc;
  int e_rd_addr, e_addr, e_len;
  logic [31:0] e_data;

  function automatic logic [31:0] m_payload(input int idx);
    int v, t, n;
    if (idx < m_cnt) begin v = m_vend[idx]; t = m_typ[idx]; end
    else begin v = 16'hFFFF; t = 8'hFF; end
    n = (idx + 1 < m_cnt) ? idx + 1 : 0;
    return {n[7:0], t[7:0], v[15:0]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_ph = 0; m_cnt = 2; e_len = 0;
      e_rd_en = 0; e_we = 0; e_done = 0; e_disc = 0; e_rd_addr = 0; e_addr = 0; e_data = 0;
      m_vend[0] = 1; m_typ[0] = 0; m_vend[1] = 1; m_typ[1] = 1;
    end else begin
      e_rd_en = 0; e_we = 0; e_done = 0; e_disc = 0;
      if (m_busy == 0) begin
        if (tbl_we && tbl_idx >= 2) begin m_vend[tbl_idx] = tbl_vendor; m_typ[tbl_idx] = tbl_type; end
        if (cnt_we) m_cnt = (cnt_val < 2) ? 2 : (cnt_val > 256) ? 256 : int'(cnt_val);
        if (start) begin m_busy = 1; m_ph = 1; e_rd_en = 1; e_rd_addr = 1; end
      end else begin
        case (m_ph)
          1: begin e_rd_en = 1; e_rd_addr = 2; m_ph = 2; end
          2: begin m_len = int'(reqmem[1][17:0]); m_ph = 3; end
          3: begin
            m_idx = int'(reqmem[2][7:0]);
            if (m_len < 3) begin e_disc = 1; e_len = 0; m_busy = 0; end
            else begin e_we = 1; e_addr = 0; e_data = 32'h1; m_ph = 4; end
          end
          4: begin e_we = 1; e_addr = 1; e_data = 32'h3; m_ph = 5; end
          5: begin e_we = 1; e_addr = 2; e_data = m_payload(m_idx); m_ph = 6; end
          default: begin e_done = 1; e_len = 3; m_busy = 0; end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      cmp("R2 req_rd_en", 32'(req_rd_en), 32'(e_rd_en));
      if (e_rd_en) cmp("R2 req_rd_addr", 32'(req_rd_addr), e_rd_addr);
      cmp("R3 discard", 32'(discard), 32'(e_disc));
      cmp("R11 done", 32'(done), 32'(e_done));
      cmp("R11 rsp_len", 32'(rsp_len), e_len);
      cmp("R4 rsp_we", 32'(rsp_we), 32'(e_we));
      if (e_we) begin
        cmp("R4 rsp_addr", 32'(rsp_addr), e_addr);
        cmp(e_addr == 2 ? "R5 payload" : "R4 header", rsp_data, e_data);
      end
      if (rsp_we && rsp_addr == 2'd2) last_pay = rsp_data;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      mismatched++;
      $display("FAIL watchdog got timeout exp finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // result: 1 = done, 2 = discard, 0 = nothing
  task automatic run_req(input logic [31:0] lenw, input int idx, output int result);
    reqmem[0] = 32'h0000_0001; reqmem[1] = lenw; reqmem[2] = 32'(idx); reqmem[3] = 0;
    result = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    for (int i = 0; i < 20 && result == 0; i++) begin
      @(negedge clk);
      if (done) result = 1;
      else if (discard) result = 2;
    end
    @(negedge clk);
  endtask

  task automatic put_ent(input int idx, input logic [15:0] v, input logic [7:0] t);
    @(negedge clk); tbl_we = 1; tbl_idx = AW'(idx); tbl_vendor = v; tbl_type = t;
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic put_cnt(input int c);
    @(negedge clk); cnt_we = 1; cnt_val = CW'(c);
    @(negedge clk); cnt_we = 0;
  endtask

  initial begin
    int r;
    reqmem[0] = 0; reqmem[1] = 0; reqmem[2] = 0; reqmem[3] = 0;
    repeat (3) @(negedge clk);
    cmp("R1 done", 32'(done), 0);
    cmp("R1 discard", 32'(discard), 0);
    cmp("R1 rsp_we", 32'(rsp_we), 0);
    cmp("R1 req_rd_en", 32'(req_rd_en), 0);
    cmp("R1 rsp_len", 32'(rsp_len), 0);
    rst = 0;

    run_req(3, 0, r);  cmp("R5 result", r, 1);  cmp("R5 idx0", last_pay, 32'h0100_0001);
    run_req(3, 1, r);  cmp("R7 idx1 wrap", last_pay, 32'h0001_0001);
    cmp("R1 default count", last_pay[31:24], 0);
    run_req(3, 7, r);  cmp("R6 out of range", last_pay, 32'h00FF_FFFF);
    run_req(2, 0, r);  cmp("R3 short", r, 2);   cmp("R3 len0", 32'(rsp_len), 0);
    run_req(32'hFFFC_0002, 0, r); cmp("R3 high bits ignored", r, 2);
    run_req(5, 0, r);  cmp("R12 long accepted", r, 1); cmp("R12 payload", last_pay, 32'h0100_0001);

    put_cnt(4);
    put_ent(2, 16'h1234, 8'h56);
    put_ent(3, 16'hABCD, 8'h09);
    run_req(3, 2, r);  cmp("R9 count 4 idx2", last_pay, 32'h0356_1234);
    run_req(3, 3, r);  cmp("R7 last entry", last_pay, 32'h0009_ABCD);

    put_ent(0, 16'hBEEF, 8'h77);
    put_ent(1, 16'hBEEF, 8'h77);
    run_req(3, 0, r);  cmp("R8 fixed entry0", last_pay, 32'h0100_0001);
    run_req(3, 1, r);  cmp("R8 fixed entry1", last_pay, 32'h0201_0001);

    put_cnt(0);
    run_req(3, 1, r);  cmp("R9 clamp low wrap", last_pay, 32'h0001_0001);
    run_req(3, 2, r);  cmp("R9 clamp low invalid", last_pay, 32'h00FF_FFFF);

    put_cnt(300);
    put_ent(254, 16'h4444, 8'h22);
    put_ent(255, 16'h5555, 8'h33);
    run_req(3, 255, r); cmp("R9 clamp high top", last_pay, 32'h0033_5555);
    run_req(3, 254, r); cmp("R9 clamp high next", last_pay, 32'hFF22_4444);

    // writes and start during a request
    reqmem[0] = 1; reqmem[1] = 3; reqmem[2] = 2;
    @(negedge clk) start = 1;
    @(negedge clk) start = 1; tbl_we = 1; tbl_idx = 8'd2; tbl_vendor = 16'h9999;
      tbl_type = 8'h11; cnt_we = 1; cnt_val = 9'd3;
    @(negedge clk) start = 0; tbl_we = 0; cnt_we = 0;
    r = 0;
    for (int i = 0; i < 20 && r == 0; i++) begin @(negedge clk); if (done) r = 1; end
    cmp("R10 busy result", r, 1);
    cmp("R10 busy payload", last_pay, 32'h0356_1234);
    repeat (3) @(negedge clk);
    run_req(3, 2, r);   cmp("R10 entry kept", last_pay, 32'h0356_1234);
    run_req(3, 255, r); cmp("R10 count kept", last_pay, 32'h0033_5555);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule